// File: doc/BRIEF.md
# Coarse Chip-Timing Acquisition Correlator

This block finds coarse chip timing for a direct-sequence spread-spectrum receiver. Complex baseband samples arrive at eight samples per chip, so consecutive samples fall on eight sub-chip phases. The block follows three of these phases, spaced three phases apart. For each one it correlates the most recent 31 chips against a programmable length-31 spreading code. A stream is selected when its correlation magnitude rises above a programmable threshold. The index of that stream then drives the downstream stream-select multiplexers. With three phases spaced three apart, the timing error after acquisition is at most 3/8 of a chip.

A one-cycle packet-start pulse restarts acquisition. It resets the sub-chip phase, clears the done flag and restarts each stream's chip count. A stream may not trigger until it has collected two full code periods (62 chips) in the current packet. Once acquisition is declared, the done flag and the selected index stay fixed until the next packet start.

Top module: `chip_timing_acq`

## Requirements
- R1: After reset, `acq_done` is 0 and `acq_sel` is 0.
- R2: A valid sample presented in the same cycle as `pkt_start` has sub-chip phase 0. Each later valid sample advances the phase by one, modulo 8. A cycle with `smp_vld` low leaves the phase and all stream state unchanged, whatever the sample inputs carry.
- R3: Stream s (s = 0, 1, 2) takes only the samples whose sub-chip phase is 3·s. Each such sample is one chip of that stream.
- R4: Each stream computes one correlation for I and one for Q over its last 31 chips, with samples read as 7-bit two's complement. The oldest chip is weighted by code bit 0 and the newest by code bit 30. A code bit of 1 adds the chip and a code bit of 0 subtracts it.
- R5: The magnitude of a stream is |corr_I| + |corr_Q|. A stream hits only when this magnitude is strictly greater than the unsigned `thresh`.
- R6: A stream cannot hit until it has taken at least 62 chips since the last `pkt_start`. This holds even when an earlier window is perfectly aligned.
- R7: `acq_done` and `acq_sel` update on the clock edge after the edge that loaded the chip that made a stream hit.
- R8: If several streams hit in the same cycle, the lowest stream index is selected.
- R9: Once `acq_done` is 1, it and `acq_sel` hold their values until `pkt_start`. Later hits are ignored.
- R10: The edge that samples `pkt_start` high clears `acq_done`. Acquisition then starts again from the conditions in R2 and R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pkt_start | input | 1 | One-cycle pulse at packet start; restarts acquisition |
| smp_vld | input | 1 | Sample inputs carry a new sample this cycle |
| smp_i | input | 7 | In-phase sample, two's complement |
| smp_q | input | 7 | Quadrature sample, two's complement |
| code | input | 31 | Spreading code; bit 0 pairs with the oldest chip |
| thresh | input | 13 | Unsigned detection threshold |
| acq_done | output | 1 | Acquisition declared for this packet |
| acq_sel | output | 2 | Index of the selected stream |

## Verification
A chip loaded on edge n first affects the hit decision in the cycle after edge n. The resulting `acq_done`/`acq_sel` change is therefore due on edge n+1, and `pkt_start` sampled on edge 0 clears `acq_done` on that same edge 0. For every packet, the bench model replays the sample and valid pattern and predicts the edge number and the stream index. The monitor counts edges from the one that sampled `pkt_start`, reads the outputs at each falling edge, and requires `acq_done` to stay low before the predicted edge and high with the predicted index from that edge until the next packet.

// File: rtl/cta_pkg.sv
package cta_pkg;
  typedef enum logic {
    ACQ_HUNT = 1'b0,
    ACQ_HELD = 1'b1
  } acq_state_e;
endpackage

// File: rtl/cta_stream.sv
module cta_stream #(
  parameter int SMP_W     = 7,
  parameter int CODE_LEN  = 31,
  parameter int MIN_CHIPS = 62,
  parameter int PH_W      = 3,
  parameter int PHASE     = 0,
  parameter int CORR_W    = 13
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pkt_start,
  input  logic                    smp_vld,
  input  logic [PH_W-1:0]         phase_cur,
  input  logic signed [SMP_W-1:0] smp_i,
  input  logic signed [SMP_W-1:0] smp_q,
  input  logic [CODE_LEN-1:0]     code,
  input  logic [CORR_W-1:0]       thresh,
  output logic                    hit
);
  localparam int CNT_W = $clog2(MIN_CHIPS + 1);

  logic signed [SMP_W-1:0] win_i   [CODE_LEN];
  logic signed [SMP_W-1:0] win_q   [CODE_LEN];
  logic signed [SMP_W-1:0] win_i_n [CODE_LEN];
  logic signed [SMP_W-1:0] win_q_n [CODE_LEN];
  logic [CNT_W-1:0]        cnt_q, cnt_n;
  logic                    take;
  logic signed [CORR_W-1:0] acc_i, acc_q;
  logic [CORR_W-1:0]       abs_i, abs_q, mag;

  assign take = smp_vld && (phase_cur == PH_W'(PHASE));

  // next state: shift window toward index 0 (oldest), count chips
  always_comb begin
    for (int k = 0; k < CODE_LEN - 1; k++) begin
      win_i_n[k] = win_i[k+1];
      win_q_n[k] = win_q[k+1];
    end
    win_i_n[CODE_LEN-1] = smp_i;
    win_q_n[CODE_LEN-1] = smp_q;
    if (pkt_start)
      cnt_n = take ? CNT_W'(1) : '0;
    else if (take && (cnt_q != CNT_W'(MIN_CHIPS)))
      cnt_n = cnt_q + 1'b1;
    else
      cnt_n = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < CODE_LEN; k++) begin
        win_i[k] <= '0;
        win_q[k] <= '0;
      end
      cnt_q <= '0;
    end else begin
      if (take) begin
        for (int k = 0; k < CODE_LEN; k++) begin
          win_i[k] <= win_i_n[k];
          win_q[k] <= win_q_n[k];
        end
      end
      cnt_q <= cnt_n;
    end
  end

  // signed correlation over the full window
  always_comb begin
    acc_i = '0;
    acc_q = '0;
    for (int k = 0; k < CODE_LEN; k++) begin
      if (code[k]) begin
        acc_i = acc_i + CORR_W'(win_i[k]);
        acc_q = acc_q + CORR_W'(win_q[k]);
      end else begin
        acc_i = acc_i - CORR_W'(win_i[k]);
        acc_q = acc_q - CORR_W'(win_q[k]);
      end
    end
    abs_i = acc_i[CORR_W-1] ? CORR_W'(-acc_i) : CORR_W'(acc_i);
    abs_q = acc_q[CORR_W-1] ? CORR_W'(-acc_q) : CORR_W'(acc_q);
    mag   = abs_i + abs_q;
  end

  assign hit = (cnt_q == CNT_W'(MIN_CHIPS)) && (mag > thresh);

  // R3
  newest_tap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (win_i[CODE_LEN-1] == $past(smp_i)) && (win_q[CODE_LEN-1] == $past(smp_q)));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !pkt_start) |=> $stable(acc_i) && $stable(acc_q) && $stable(cnt_q));

  // R6
  arm_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_start |=> !hit);
endmodule

// File: rtl/cta_pick.sv
module cta_pick
  import cta_pkg::*;
#(
  parameter int NSTRM = 3,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pkt_start,
  input  logic [NSTRM-1:0] hit,
  output logic             done,
  output logic [SEL_W-1:0] sel
);
  acq_state_e       st_q, st_n;
  logic [SEL_W-1:0] sel_q, sel_n, first;

  always_comb begin
    first = '0;
    for (int s = NSTRM - 1; s >= 0; s--)
      if (hit[s]) first = SEL_W'(s);
  end

  always_comb begin
    st_n  = st_q;
    sel_n = sel_q;
    if (pkt_start) begin
      st_n = ACQ_HUNT;
    end else if ((st_q == ACQ_HUNT) && (|hit)) begin
      st_n  = ACQ_HELD;
      sel_n = first;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ACQ_HUNT;
      sel_q <= '0;
    end else begin
      st_q  <= st_n;
      sel_q <= sel_n;
    end
  end

  assign done = (st_q == ACQ_HELD);
  assign sel  = sel_q;

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !pkt_start) |=> done && $stable(sel));

  // R10
  rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_start |=> !done);

  // R7
  rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && !pkt_start && (|hit)) |=> done);

  // R8
  lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ((($past(hit) >> sel) & NSTRM'(1)) != '0) &&
                    (($past(hit) & ((NSTRM'(1) << sel) - NSTRM'(1))) == '0));
endmodule

// File: rtl/chip_timing_acq.sv
module chip_timing_acq #(
  parameter int SMP_W     = 7,
  parameter int CODE_LEN  = 31,
  parameter int OSR       = 8,
  parameter int NSTRM     = 3,
  parameter int PH_BASE   = 0,
  parameter int PH_STEP   = 3,
  parameter int MIN_CHIPS = 62,
  parameter int THR_W     = SMP_W + $clog2(CODE_LEN) + 1,
  parameter int SEL_W     = (NSTRM > 1) ? $clog2(NSTRM) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pkt_start,
  input  logic                smp_vld,
  input  logic [SMP_W-1:0]    smp_i,
  input  logic [SMP_W-1:0]    smp_q,
  input  logic [CODE_LEN-1:0] code,
  input  logic [THR_W-1:0]    thresh,
  output logic                acq_done,
  output logic [SEL_W-1:0]    acq_sel
);
  localparam int PH_W = $clog2(OSR);

  logic [PH_W-1:0]  ph_q, ph_cur, ph_n;
  logic [NSTRM-1:0] hit;

  always_comb begin
    ph_cur = pkt_start ? '0 : ph_q;
    if (smp_vld)
      ph_n = (ph_cur == PH_W'(OSR - 1)) ? '0 : ph_cur + 1'b1;
    else
      ph_n = ph_cur;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_n;
  end

  for (genvar s = 0; s < NSTRM; s++) begin : g_strm
    cta_stream #(
      .SMP_W    (SMP_W),
      .CODE_LEN (CODE_LEN),
      .MIN_CHIPS(MIN_CHIPS),
      .PH_W     (PH_W),
      .PHASE    (PH_BASE + s * PH_STEP),
      .CORR_W   (THR_W)
    ) u_strm (
      .clk      (clk),
      .rst_n    (rst_n),
      .pkt_start(pkt_start),
      .smp_vld  (smp_vld),
      .phase_cur(ph_cur),
      .smp_i    (smp_i),
      .smp_q    (smp_q),
      .code     (code),
      .thresh   (thresh),
      .hit      (hit[s])
    );
  end

  cta_pick #(
    .NSTRM(NSTRM),
    .SEL_W(SEL_W)
  ) u_pick (
    .clk      (clk),
    .rst_n    (rst_n),
    .pkt_start(pkt_start),
    .hit      (hit),
    .done     (acq_done),
    .sel      (acq_sel)
  );

  // R2
  phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && !pkt_start) |=>
      ph_q == (($past(ph_q) == PH_W'(OSR - 1)) ? PH_W'(0) : PH_W'($past(ph_q) + 1'b1)));

  // R2
  phase_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_vld && !pkt_start) |=> $stable(ph_q));
endmodule

// File: tb/chip_timing_acq_test.sv
`timescale 1ns/1ps
module chip_timing_acq_test;
  localparam int MAXN = 800;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pkt_start = 1'b0;
  logic        smp_vld = 1'b0;
  logic [6:0]  smp_i = '0;
  logic [6:0]  smp_q = '0;
  logic [30:0] code = 31'h1A5C9E1B;
  logic [12:0] thresh = '0;
  logic        acq_done;
  logic [1:0]  acq_sel;

  always #2 clk = ~clk;

  chip_timing_acq uut (
    .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start), .smp_vld(smp_vld),
    .smp_i(smp_i), .smp_q(smp_q), .code(code), .thresh(thresh),
    .acq_done(acq_done), .acq_sel(acq_sel)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  bit    vld_a [MAXN];
  int    si_a  [MAXN];
  int    sq_a  [MAXN];
  int    q_cyc [$];
  int    q_idx [$];
  string q_tag [$];

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // stimulus: mask selects phases that carry the code-modulated chip
  task automatic gen(input int len, input logic [7:0] mask, input int ai,
                     input int aq, input bit noisy, input int gap);
    int m;
    m = 0;
    for (int c = 0; c < len; c++) begin
      vld_a[c] = (gap == 0) || ((c % gap) != gap - 1);
      if (vld_a[c]) begin
        int p, j, sg;
        p  = m % 8;
        j  = m / 8;
        sg = code[j % 31] ? 1 : -1;
        if (mask[p]) begin
          si_a[c] = ai * sg;
          sq_a[c] = aq * sg;
        end else if (noisy) begin
          si_a[c] = ((m * 37 + 5) % 9) - 4;
          sq_a[c] = ((m * 53 + 1) % 7) - 3;
        end else begin
          si_a[c] = 0;
          sq_a[c] = 0;
        end
        m++;
      end else begin
        si_a[c] = -64;   // junk on invalid cycles (R2: ignored)
        sq_a[c] = -64;
      end
    end
  endtask

  // requirement model: R2..R8, edge index of the expected rise
  task automatic model(input int len, input int thr, output int ecyc, output int eidx);
    int wi [3][31];
    int wq [3][31];
    int cnt [3];
    int ph;
    ph = 0;
    ecyc = -1;
    eidx = 0;
    for (int s = 0; s < 3; s++) begin
      cnt[s] = 0;
      for (int k = 0; k < 31; k++) begin wi[s][k] = 0; wq[s][k] = 0; end
    end
    for (int c = 0; c < len - 1; c++) begin
      if (vld_a[c]) begin
        for (int s = 0; s < 3; s++) begin
          if (ph == 3 * s) begin
            for (int k = 0; k < 30; k++) begin wi[s][k] = wi[s][k+1]; wq[s][k] = wq[s][k+1]; end
            wi[s][30] = si_a[c];
            wq[s][30] = sq_a[c];
            cnt[s]++;
          end
        end
        ph = (ph + 1) % 8;
      end
      for (int s = 0; s < 3; s++) begin
        if (ecyc < 0 && cnt[s] >= 62) begin
          int ci, cq, mg;
          ci = 0; cq = 0;
          for (int k = 0; k < 31; k++) begin
            ci += code[k] ? wi[s][k] : -wi[s][k];
            cq += code[k] ? wq[s][k] : -wq[s][k];
          end
          mg = (ci < 0 ? -ci : ci) + (cq < 0 ? -cq : cq);
          if (mg > thr) begin ecyc = c + 1; eidx = s; end
        end
      end
      if (ecyc >= 0) break;
    end
  endtask

  // driver: predict, push to scoreboard, then drive the packet
  task automatic run_pkt(input int len, input int thr, input string tag);
    int ec, ei;
    model(len, thr, ec, ei);
    q_cyc.push_back(ec);
    q_idx.push_back(ei);
    q_tag.push_back(tag);
    for (int c = 0; c < len; c++) begin
      @(negedge clk);
      pkt_start = (c == 0);
      if (c == 0) thresh = 13'(thr);
      smp_vld = vld_a[c];
      smp_i   = 7'(si_a[c]);
      smp_q   = 7'(sq_a[c]);
    end
  endtask

  // monitor
  logic  pk_edge = 1'b0;
  int    mcyc = 0;
  int    ecyc = -1;
  int    eidx = 0;
  string etag = "R1";

  always @(posedge clk) pk_edge <= pkt_start;

  always @(negedge clk) begin
    if (rst_n) begin
      bit exp_done;
      if (pk_edge) begin
        mcyc = 0;
        if (q_cyc.size() > 0) begin
          ecyc = q_cyc.pop_front();
          eidx = q_idx.pop_front();
          etag = q_tag.pop_front();
        end
      end else begin
        mcyc++;
      end
      exp_done = (ecyc >= 0) && (mcyc >= ecyc);
      n_chk++;
      if (acq_done !== exp_done) begin
        n_bad++;
        $display("FAIL %s/R7: edge %0d acq_done=%b expected %b", etag, mcyc, acq_done, exp_done);
      end else if (exp_done && (acq_sel !== 2'(eidx))) begin
        n_bad++;
        $display("FAIL %s/R9: edge %0d acq_sel=%0d expected %0d", etag, mcyc, acq_sel, eidx);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    n_chk++;
    if (acq_done !== 1'b0 || acq_sel !== 2'd0) begin
      n_bad++;
      $display("FAIL R1: acq_done=%b acq_sel=%0d expected 0 0", acq_done, acq_sel);
    end
    // R3, R4: code only on phase 3 -> stream 1
    gen(520, 8'b0000_1000, 20, 0, 1'b1, 0);
    run_pkt(520, 400, "R3");
    // R8: every phase aligned, negative Q -> tie, stream 0
    gen(520, 8'hFF, 15, -15, 1'b1, 0);
    run_pkt(520, 400, "R8");
    // R5: threshold above any reachable magnitude
    gen(520, 8'hFF, 30, 30, 1'b0, 0);
    run_pkt(520, 4095, "R5");
    // R2: valid gaps with junk samples, code on phase 6 -> stream 2
    gen(700, 8'b0100_0000, 20, 10, 1'b1, 5);
    run_pkt(700, 300, "R2");
    // R5: peak equals threshold exactly -> no hit
    gen(520, 8'b0000_0001, 10, 0, 1'b0, 0);
    run_pkt(520, 310, "R5");
    // R6: one below peak; aligned window at chip 30 must not trigger
    run_pkt(520, 309, "R6");
    // R10: re-arm after a held detection (R9 hold covered above)
    gen(520, 8'b0000_1000, 20, 0, 1'b1, 0);
    run_pkt(520, 400, "R10");
    @(negedge clk);
    pkt_start = 1'b0;
    smp_vld   = 1'b0;
    repeat (20) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end
endmodule